// File: doc/BRIEF.md
# Tile Local Interconnect Switch

This block is the programmable routing fabric of one logic tile holding eight slices of a four-input lookup table and a flip-flop. It owns a bank of 48 local wires. Each local wire is driven through a multiplexer whose candidates are a few slice outputs of this tile and a few local wires of the eight surrounding tiles. Every slice clock pin and every lookup-table input pin then takes its value through a second, smaller multiplexer over a fixed subset of the local wires. The connectivity is deliberately sparse. Each destination sees only the sources that fall on its modular stride: four-wide across slices and pins, eight-wide across neighbours. A full crossbar is not provided.

Every destination has a select field, and code 0 leaves it undriven, which reads as logic 0. All select fields sit in one serial configuration chain that shifts while `cfg_en` is high. The tile position within the grid is a parameter. Neighbours that would lie outside the grid are treated as not existing, so their link codes give 0 and their input bits are never looked at. Data moves straight through the multiplexers with no register in the path, and all pins are plain control and data signals with no handshake.

Top module: `tile_local_switch`

## Requirements
- R1: Asynchronous active-low reset clears every select field, so every local wire, slice clock and LUT input pin reads 0 and `cfg_out` reads 0.
- R2: On each rising clock edge with `cfg_en` high, the 448-bit chain moves up by one place, `cfg_in` enters bit 0, and `cfg_out` shows bit 447. The select for local wire i is the 6-bit field at bits [6i+5:6i]. The select for pin s of slice z is the 4-bit field starting at bit 288+4(5z+s), where s=0 is the clock pin and s=1..4 is LUT input s-1.
- R3: While `cfg_en` is low, no select field and no value of `cfg_out` changes, whatever `cfg_in` does.
- R4: On local wire i, code 0 gives 0. Codes 1..4 pick slice outputs: with z = (i mod 4) + 4m, code 1+2m gives `slc_f[z]` and code 2+2m gives `slc_q[z]`.
- R5: On local wire i, code 5+6n+p (n in 0..7, p in 0..5) picks local wire j = ((i+n+1) mod 8) + 8p of neighbour n, read from `nbr_in[48n+j]`. The neighbours are numbered n=0..7 at offsets (dx,dy) = (-1,-1), (-1,0), (-1,+1), (0,-1), (0,+1), (+1,-1), (+1,0), (+1,+1).
- R6: On a local wire, codes 53..63 give 0.
- R7: A neighbour whose position lies outside 0..GRID_W-1 by 0..GRID_H-1 has no link. Its codes give 0, and its `nbr_in` bits have no effect on any output.
- R8: On the clock pin of any slice, code c in 1..12 gives local wire 4(c-1). Code 0 and codes 13..15 give 0.
- R9: On LUT input k of any slice, code c in 1..12 gives local wire k+4(c-1). Code 0 and codes 13..15 give 0.
- R10: Changes on `slc_f`, `slc_q` and `nbr_in` reach all outputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (chain top bit) |
| slc_f | input | 8 | LUT outputs of the eight slices |
| slc_q | input | 8 | Flip-flop outputs of the eight slices |
| nbr_in | input | 384 | Local wires of the eight neighbours, 48 per neighbour |
| loc_out | output | 48 | Local wires of this tile |
| slc_clk | output | 8 | Clock pin per slice |
| lut_in | output | 32 | LUT input pins, slice z input k at bit 4z+k |

## Verification
The bench uses the default eight-slice, four-input geometry in a 32 by 32 grid and places three copies: an interior tile at (1,1) with all eight neighbours, a corner tile at (0,0) with three neighbours, and a right-edge tile at (31,12) with five neighbours. That geometry is small enough to load every one of the 64 local codes and 16 pin codes into every field, which reaches every neighbour slot, every present and absent link, and every out-of-range code. Random legal images then mix different codes across fields. The chain is checked by draining each old image through `cfg_out` while the next image loads.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  localparam int unsigned NBR_COUNT = 8;

  // Neighbour numbering fixes the code layout of every local wire.
  function automatic int nbr_dx(input int n);
    case (n)
      0, 1, 2: return -1;
      3, 4:    return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int nbr_dy(input int n);
    case (n)
      0, 3, 5: return -1;
      1, 6:    return 0;
      default: return 1;
    endcase
  endfunction

  // Bit n set when neighbour n lies inside the grid.
  function automatic logic [NBR_COUNT-1:0] nbr_present(input int x, input int y,
                                                        input int w, input int h);
    logic [NBR_COUNT-1:0] m;
    int nx;
    int ny;
    m = '0;
    for (int n = 0; n < int'(NBR_COUNT); n++) begin
      nx = x + nbr_dx(n);
      ny = y + nbr_dy(n);
      m[n] = (nx >= 0) && (nx < w) && (ny >= 0) && (ny < h);
    end
    return m;
  endfunction

endpackage

// File: rtl/tsw_cfg_chain.sv
module tsw_cfg_chain #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [WIDTH-1:0] q,
  output logic             shift_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[WIDTH-2:0], shift_in};
    end
  end

  assign shift_out = q[WIDTH-1];

endmodule

// File: rtl/tsw_sel_mux.sv
// Code 0 and codes above N_SRC leave the output at 0; code c picks src[c-1].
module tsw_sel_mux #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned SEL_W = $clog2(N_SRC + 1)
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] src,
  output logic             pick
);

  always_comb begin
    pick = 1'b0;
    for (int c = 1; c <= int'(N_SRC); c++) begin
      if (sel == SEL_W'(c)) pick = src[c-1];
    end
  end

endmodule

// File: rtl/tile_local_switch.sv
module tile_local_switch
  import tsw_pkg::*;
#(
  parameter int unsigned N_SLICE     = 8,
  parameter int unsigned LUT_K       = 4,
  parameter int unsigned EXTRA_WIRES = 8,
  parameter int unsigned IN_STRIDE   = 4,
  parameter int unsigned OUT_STRIDE  = 4,
  parameter int unsigned NBR_STRIDE  = 8,
  parameter int          GRID_W      = 32,
  parameter int          GRID_H      = 32,
  parameter int          TILE_X      = 1,
  parameter int          TILE_Y      = 1
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   cfg_en,
  input  logic                                                   cfg_in,
  output logic                                                   cfg_out,
  input  logic [N_SLICE-1:0]                                     slc_f,
  input  logic [N_SLICE-1:0]                                     slc_q,
  input  logic [NBR_COUNT*(N_SLICE*(LUT_K+1)+EXTRA_WIRES)-1:0]   nbr_in,
  output logic [N_SLICE*(LUT_K+1)+EXTRA_WIRES-1:0]               loc_out,
  output logic [N_SLICE-1:0]                                     slc_clk,
  output logic [N_SLICE*LUT_K-1:0]                               lut_in
);

  localparam int unsigned NLOCAL    = N_SLICE * (LUT_K + 1) + EXTRA_WIRES;
  localparam int unsigned OUT_PER   = N_SLICE / OUT_STRIDE;
  localparam int unsigned NBR_PER   = NLOCAL / NBR_STRIDE;
  localparam int unsigned LOC_SRC   = 2 * OUT_PER + NBR_COUNT * NBR_PER;
  localparam int unsigned LOC_SEL_W = $clog2(LOC_SRC + 1);
  localparam int unsigned PIN_SRC   = NLOCAL / IN_STRIDE;
  localparam int unsigned PIN_SEL_W = $clog2(PIN_SRC + 1);
  localparam int unsigned PINS_PER  = LUT_K + 1;
  localparam int unsigned N_PIN     = N_SLICE * PINS_PER;
  localparam int unsigned PIN_BASE  = NLOCAL * LOC_SEL_W;
  localparam int unsigned CFG_W     = PIN_BASE + N_PIN * PIN_SEL_W;
  localparam logic [NBR_COUNT-1:0] NBR_LIVE = nbr_present(TILE_X, TILE_Y, GRID_W, GRID_H);

  logic [CFG_W-1:0] cfg_q;

  tsw_cfg_chain #(.WIDTH(CFG_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (cfg_en),
    .shift_in  (cfg_in),
    .q         (cfg_q),
    .shift_out (cfg_out)
  );

  // Local wire stage: slice outputs on the same lane, then neighbour slots.
  for (genvar gi = 0; gi < int'(NLOCAL); gi++) begin : g_wire
    logic [LOC_SRC-1:0] src;

    for (genvar gm = 0; gm < int'(OUT_PER); gm++) begin : g_slice_src
      localparam int unsigned Z = (gi % OUT_STRIDE) + OUT_STRIDE * gm;
      assign src[2*gm]     = slc_f[Z];
      assign src[2*gm + 1] = slc_q[Z];
    end

    for (genvar gn = 0; gn < int'(NBR_COUNT); gn++) begin : g_nbr
      for (genvar gp = 0; gp < int'(NBR_PER); gp++) begin : g_slot
        localparam int unsigned J    = ((gi + gn + 1) % NBR_STRIDE) + NBR_STRIDE * gp;
        localparam int unsigned SLOT = 2 * OUT_PER + gn * NBR_PER + gp;
        if (NBR_LIVE[gn]) begin : g_link
          assign src[SLOT] = nbr_in[gn*NLOCAL + J];
        end else begin : g_absent
          assign src[SLOT] = 1'b0;
        end
      end
    end

    tsw_sel_mux #(.N_SRC(LOC_SRC), .SEL_W(LOC_SEL_W)) u_mux (
      .sel  (cfg_q[gi*LOC_SEL_W +: LOC_SEL_W]),
      .src  (src),
      .pick (loc_out[gi])
    );
  end

  // Pin stage: each slice pin taps one stride lane of the local wires.
  for (genvar gz = 0; gz < int'(N_SLICE); gz++) begin : g_slice
    for (genvar gs = 0; gs < int'(PINS_PER); gs++) begin : g_pin
      localparam int unsigned OFF  = (gs == 0) ? 0 : (gs - 1) % IN_STRIDE;
      localparam int unsigned FBIT = PIN_BASE + (gz * PINS_PER + gs) * PIN_SEL_W;
      logic [PIN_SRC-1:0] src;
      logic               pick;

      for (genvar gc = 0; gc < int'(PIN_SRC); gc++) begin : g_tap
        assign src[gc] = loc_out[OFF + IN_STRIDE * gc];
      end

      tsw_sel_mux #(.N_SRC(PIN_SRC), .SEL_W(PIN_SEL_W)) u_mux (
        .sel  (cfg_q[FBIT +: PIN_SEL_W]),
        .src  (src),
        .pick (pick)
      );

      if (gs == 0) begin : g_clk
        assign slc_clk[gz] = pick;
      end else begin : g_lut
        assign lut_in[gz*LUT_K + gs - 1] = pick;
      end
    end
  end

endmodule

// File: rtl/tile_local_switch_chk.sv
module tile_local_switch_chk
  import tsw_pkg::*;
#(
  parameter int unsigned N_SLICE     = 8,
  parameter int unsigned LUT_K       = 4,
  parameter int unsigned EXTRA_WIRES = 8,
  parameter int unsigned IN_STRIDE   = 4,
  parameter int unsigned OUT_STRIDE  = 4,
  parameter int unsigned NBR_STRIDE  = 8,
  parameter int          GRID_W      = 32,
  parameter int          GRID_H      = 32,
  parameter int          TILE_X      = 1,
  parameter int          TILE_Y      = 1,
  parameter int unsigned NLOCAL      = N_SLICE * (LUT_K + 1) + EXTRA_WIRES,
  parameter int unsigned CFG_W       = 448
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_en,
  input logic                          cfg_out,
  input logic [N_SLICE-1:0]            slc_f,
  input logic [N_SLICE-1:0]            slc_q,
  input logic [NBR_COUNT*NLOCAL-1:0]   nbr_in,
  input logic [NLOCAL-1:0]             loc_out,
  input logic [N_SLICE-1:0]            slc_clk,
  input logic [N_SLICE*LUT_K-1:0]      lut_in,
  input logic [CFG_W-1:0]              cfg_q
);

  localparam logic [NBR_COUNT-1:0] NBR_LIVE = nbr_present(TILE_X, TILE_Y, GRID_W, GRID_H);

  function automatic logic [NLOCAL-1:0] lane_mask(input int off);
    logic [NLOCAL-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NLOCAL); i++) if (i % int'(IN_STRIDE) == off) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [N_SLICE-1:0] slice_lane(input int off);
    logic [N_SLICE-1:0] m;
    m = '0;
    for (int z = 0; z < int'(N_SLICE); z++) if (z % int'(OUT_STRIDE) == off) m[z] = 1'b1;
    return m;
  endfunction

  logic [NBR_COUNT*NLOCAL-1:0] live_bits;
  for (genvar gn = 0; gn < int'(NBR_COUNT); gn++) begin : g_live
    assign live_bits[gn*NLOCAL +: NLOCAL] = {NLOCAL{NBR_LIVE[gn]}};
  end

  assert_cleared_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == '0) |-> (loc_out == '0 && slc_clk == '0 && lut_in == '0));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> ($stable(cfg_q) && $stable(cfg_out)));

  assert_absent_nbr_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slc_f == '0 && slc_q == '0 && (nbr_in & live_bits) == '0) |-> (loc_out == '0));

  for (genvar gi = 0; gi < int'(NLOCAL); gi++) begin : g_wire
    localparam logic [N_SLICE-1:0] SL = slice_lane(gi % OUT_STRIDE);
    assert_slice_lane_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (nbr_in == '0 && loc_out[gi]) |-> (((slc_f | slc_q) & SL) != '0));
  end

  for (genvar gz = 0; gz < int'(N_SLICE); gz++) begin : g_slice
    localparam logic [NLOCAL-1:0] CLK_LANE = lane_mask(0);
    assert_clk_on_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slc_clk[gz] |-> ((loc_out & CLK_LANE) != '0));
    for (genvar gk = 0; gk < int'(LUT_K); gk++) begin : g_in
      localparam logic [NLOCAL-1:0] IN_LANE = lane_mask(gk % IN_STRIDE);
      assert_lut_on_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lut_in[gz*LUT_K + gk] |-> ((loc_out & IN_LANE) != '0));
    end
  end

endmodule

bind tile_local_switch tile_local_switch_chk #(
  .N_SLICE     (N_SLICE),
  .LUT_K       (LUT_K),
  .EXTRA_WIRES (EXTRA_WIRES),
  .IN_STRIDE   (IN_STRIDE),
  .OUT_STRIDE  (OUT_STRIDE),
  .NBR_STRIDE  (NBR_STRIDE),
  .GRID_W      (GRID_W),
  .GRID_H      (GRID_H),
  .TILE_X      (TILE_X),
  .TILE_Y      (TILE_Y),
  .NLOCAL      (NLOCAL),
  .CFG_W       (CFG_W)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_en  (cfg_en),
  .cfg_out (cfg_out),
  .slc_f   (slc_f),
  .slc_q   (slc_q),
  .nbr_in  (nbr_in),
  .loc_out (loc_out),
  .slc_clk (slc_clk),
  .lut_in  (lut_in),
  .cfg_q   (cfg_q)
);

// File: tb/test_tile_local_switch.sv
`timescale 1ns/1ps
module test_tile_local_switch;

  localparam int NS = 8, LK = 4, NL = 48, NN = 8;
  localparam int LSW = 6, PSW = 4, PB = 288, CW = 448, NT = 3;
  localparam int GW = 32, GH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_in = 1'b0;
  logic [NS-1:0] slc_f = '0;
  logic [NS-1:0] slc_q = '0;
  logic [NN*NL-1:0] nbr_in = '0;
  logic [NT-1:0] cfg_out;
  logic [NL-1:0] loc_o [NT];
  logic [NS-1:0] clk_o [NT];
  logic [NS*LK-1:0] lut_o [NT];
  logic [CW-1:0] img = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tile_local_switch #(.TILE_X(1), .TILE_Y(1)) i_tile_local_switch (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out[0]),
    .slc_f(slc_f), .slc_q(slc_q), .nbr_in(nbr_in),
    .loc_out(loc_o[0]), .slc_clk(clk_o[0]), .lut_in(lut_o[0]));

  tile_local_switch #(.TILE_X(0), .TILE_Y(0)) i_tile_local_switch_corner (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out[1]),
    .slc_f(slc_f), .slc_q(slc_q), .nbr_in(nbr_in),
    .loc_out(loc_o[1]), .slc_clk(clk_o[1]), .lut_in(lut_o[1]));

  tile_local_switch #(.TILE_X(31), .TILE_Y(12)) i_tile_local_switch_edge (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out[2]),
    .slc_f(slc_f), .slc_q(slc_q), .nbr_in(nbr_in),
    .loc_out(loc_o[2]), .slc_clk(clk_o[2]), .lut_in(lut_o[2]));

  function automatic int tile_x(input int t);
    return (t == 0) ? 1 : (t == 1) ? 0 : 31;
  endfunction
  function automatic int tile_y(input int t);
    return (t == 0) ? 1 : (t == 1) ? 0 : 12;
  endfunction

  // R7: neighbour n exists only when its position lies inside the grid.
  function automatic bit live(input int t, input int n);
    int ox;
    int oy;
    ox = (n < 3) ? -1 : (n < 5) ? 0 : 1;
    oy = (n == 0 || n == 3 || n == 5) ? -1 : (n == 1 || n == 6) ? 0 : 1;
    ox = ox + tile_x(t);
    oy = oy + tile_y(t);
    return (ox >= 0 && ox < GW && oy >= 0 && oy < GH);
  endfunction

  // R4 R5 R6 R7: expected local wires from the current image and inputs.
  function automatic logic [NL-1:0] exp_loc(input int t);
    logic [NL-1:0] r;
    r = '0;
    for (int i = 0; i < NL; i++) begin
      int c;
      c = int'(img[i*LSW +: LSW]);
      if (c >= 1 && c <= 4) begin
        int z;
        z = (i % 4) + 4 * ((c - 1) / 2);
        r[i] = ((c - 1) % 2 == 1) ? slc_q[z] : slc_f[z];
      end else if (c >= 5 && c <= 52) begin
        int n;
        int p;
        n = (c - 5) / 6;
        p = (c - 5) % 6;
        if (live(t, n)) r[i] = nbr_in[n*NL + ((i + n + 1) % 8) + 8*p];
      end
    end
    return r;
  endfunction

  // R8 R9: expected pins from the expected local wires.
  task automatic exp_pins(input logic [NL-1:0] lw, output logic [NS-1:0] ec,
                          output logic [NS*LK-1:0] el);
    ec = '0;
    el = '0;
    for (int z = 0; z < NS; z++) begin
      for (int s = 0; s <= LK; s++) begin
        int c;
        int off;
        logic v;
        c = int'(img[PB + (z*5 + s)*PSW +: PSW]);
        off = (s == 0) ? 0 : s - 1;
        v = (c >= 1 && c <= 12) ? lw[off + 4*(c - 1)] : 1'b0;
        if (s == 0) ec[z] = v;
        else el[z*LK + s - 1] = v;
      end
    end
  endtask

  task automatic compare_all(input string rq_loc, input string rq_pin);
    for (int t = 0; t < NT; t++) begin
      logic [NL-1:0] el;
      logic [NS-1:0] ec;
      logic [NS*LK-1:0] eu;
      el = exp_loc(t);
      exp_pins(el, ec, eu);
      n_chk++;
      if (loc_o[t] !== el) begin
        n_bad++;
        $display("FAIL %s tile%0d local wires: got %h expected %h", rq_loc, t, loc_o[t], el);
      end
      n_chk++;
      if (clk_o[t] !== ec) begin
        n_bad++;
        $display("FAIL %s tile%0d slice clocks: got %h expected %h", rq_pin, t, clk_o[t], ec);
      end
      n_chk++;
      if (lut_o[t] !== eu) begin
        n_bad++;
        $display("FAIL %s tile%0d lut inputs: got %h expected %h", rq_pin, t, lut_o[t], eu);
      end
    end
  endtask

  // R2: shift a new image in; the old image must drain out of cfg_out.
  task automatic load_cfg(input logic [CW-1:0] nimg);
    logic [CW-1:0] drained [NT];
    for (int b = CW - 1; b >= 0; b--) begin
      @(negedge clk);
      for (int t = 0; t < NT; t++) drained[t][b] = cfg_out[t];
      cfg_en = 1'b1;
      cfg_in = nimg[b];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    for (int t = 0; t < NT; t++) begin
      n_chk++;
      if (drained[t] !== img) begin
        n_bad++;
        $display("FAIL R2 tile%0d drained image: got %h expected %h", t, drained[t], img);
      end
    end
    img = nimg;
  endtask

  task automatic set_pattern(input int pi);
    case (pi)
      0: begin slc_f = '1; slc_q = '1; nbr_in = '1; end
      1: begin slc_f = 8'h55; slc_q = 8'hAA; nbr_in = {48{8'hA5}}; end
      default: begin
        slc_f = 8'($urandom);
        slc_q = 8'($urandom);
        for (int w = 0; w < NN*NL/32; w++) nbr_in[w*32 +: 32] = $urandom;
      end
    endcase
  endtask

  task automatic sweep_patterns(input string rq_loc, input string rq_pin);
    for (int pi = 0; pi < 4; pi++) begin
      @(negedge clk);
      set_pattern(pi);
      #1;
      compare_all(rq_loc, rq_pin);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got still running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] nimg;
    // R1: reset dominates a shifting chain and all-ones inputs.
    slc_f = '1; slc_q = '1; nbr_in = '1;
    cfg_en = 1'b1; cfg_in = 1'b1;
    repeat (4) @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      n_chk++;
      if (loc_o[t] !== '0 || clk_o[t] !== '0 || lut_o[t] !== '0 || cfg_out[t] !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 tile%0d in reset: got %h/%h/%h/%b expected all zero",
                 t, loc_o[t], clk_o[t], lut_o[t], cfg_out[t]);
      end
    end
    cfg_en = 1'b0; cfg_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    compare_all("R1", "R1");

    // Every code in every field at once: R4 R5 R6 R7 R8 R9.
    for (int c = 0; c < 64; c++) begin
      string rq;
      for (int i = 0; i < NL; i++) nimg[i*LSW +: LSW] = LSW'(c);
      for (int d = 0; d < NS*5; d++) nimg[PB + d*PSW +: PSW] = PSW'(c % 16);
      load_cfg(nimg);
      rq = (c <= 4) ? "R4" : (c <= 52) ? "R5 R7" : "R6";
      sweep_patterns(rq, "R8 R9");
    end

    // Random legal selections mixed across fields: R2 R5 R8 R9.
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < NL; i++) nimg[i*LSW +: LSW] = LSW'($urandom_range(0, 52));
      for (int d = 0; d < NS*5; d++) nimg[PB + d*PSW +: PSW] = PSW'($urandom_range(0, 12));
      load_cfg(nimg);
      sweep_patterns("R2 R5", "R2 R8 R9");
    end

    // R3: cfg_in toggles with cfg_en low; nothing may move.
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      cfg_in = 1'($urandom);
      #1;
      for (int t = 0; t < NT; t++) begin
        n_chk++;
        if (cfg_out[t] !== img[CW-1]) begin
          n_bad++;
          $display("FAIL R3 tile%0d cfg_out while idle: got %b expected %b", t, cfg_out[t], img[CW-1]);
        end
      end
      compare_all("R3", "R3");
    end
    cfg_in = 1'b0;

    // R10: inputs changed mid-phase reach outputs with no clock edge.
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      #1;
      set_pattern(2);
      #1;
      compare_all("R10", "R10");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule